// File: doc/BRIEF.md
# Synchronous Decay Bin Integrator

The block sums a continuous stream of signed converter samples into a fixed set of time bins that repeat once per transmit/receive period. Each valid strobe moves the bin pointer forward by one, so sample n lands in bin n mod NUM_BINS. The bins therefore sit at even spacing across the period, and their timing is tied to the input strobe alone. At 2.5 MS/s with 512 bins, one period lasts 204.8 µs and each bin covers 0.4 µs. Each bin's running sum lives in a dual-port RAM. A two-stage read-modify-write pipeline updates it, reading through one port and writing through the other.

After ACC_COUNT passes over all bins, the finished frame is streamed out in bin order on a valid/ready interface. Each word carries its bin index, and the final word is flagged. One chosen bin is replaced by a programmable marker word so that a display can lock onto the frame boundary. Sampling is never paused or resynchronised. The block has two RAM banks. Samples arriving during a readout go into the other bank, and the first pass of every frame loads its bins rather than adding to them, so no clearing sweep is needed.

Top module: `decay_bin_integrator`

## Requirements
- R1: Each asserted smp_valid_i assigns its sample to the next bin in sequence, wrapping from NUM_BINS-1 to 0. Cycles without smp_valid_i leave the bin pointer, the pass count and the sums untouched, whatever the length of the gap.
- R2: Sums are two's complement, SUM_W = DATA_W + log2(ACC_COUNT) bits wide. ACC_COUNT must be a power of two and at least 2. A frame of full-scale positive or negative samples yields exactly ACC_COUNT times the sample, without wrap-around.
- R3: The first pass of every frame loads each bin with its sample. Data from earlier frames never leaks into a new sum.
- R4: After NUM_BINS*ACC_COUNT samples, exactly NUM_BINS words leave on out_sum_o. out_bin_o counts 0 to NUM_BINS-1, and out_last_o is 1 only on bin NUM_BINS-1.
- R5: The word whose bin equals marker_bin_i carries marker_val_i in place of its sum. The marker inputs are sampled when the word enters the output register.
- R6: A sample for the same bin as the sample one cycle earlier adds to that sample's updated sum. This case arises when NUM_BINS is 1.
- R7: Samples of the next frame accumulate in the other bank while a readout runs, with none lost on a continuous stream. The readout must finish before the next frame completes.
- R8: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_sum_o, out_bin_o and out_last_o hold their values.
- R9: rst_ni low clears the bin pointer, the pass count, the bank select and out_valid_o. The first frame after reset starts at bin 0 with fresh sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | DATA_W | Signed input sample |
| smp_valid_i | input | 1 | Sample strobe; advances the bin pointer |
| marker_bin_i | input | BIN_W | Bin replaced by the marker on output |
| marker_val_i | input | SUM_W | Marker word |
| out_sum_o | output | SUM_W | Bin sum or marker word |
| out_bin_o | output | BIN_W | Bin index of the output word |
| out_last_o | output | 1 | Final bin of the frame |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |

## Verification
On every cycle, the assertions check the following:
- the bin pointer wraps, and it holds through strobe gaps;
- the bank flips at each frame end;
- every strobe causes a write one cycle later;
- the output holds steady under backpressure;
- out_last_o appears only with the final bin index;
- a frame never ends while a readout is still in flight.

Only the bench's scenarios can show that the sums are arithmetically correct. These scenarios cover full-scale values, first-pass loading, marker substitution, forwarding on a single-bin instance, and continuous back-to-back frames through the bank swap.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  // index width that stays legal for a count of 1
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dbi_bank_ram.sv
module dbi_bank_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 36,
  parameter int AW    = 9
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dbi_bin_seq.sv
module dbi_bin_seq import dbi_pkg::*; #(
  parameter int NUM_BINS  = 512,
  parameter int ACC_COUNT = 4096,
  localparam int BIN_W  = idx_w(NUM_BINS),
  localparam int PASS_W = idx_w(ACC_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [BIN_W-1:0] bin_o,
  output logic             first_o,
  output logic             eof_o,
  output logic             bank_o
);
  localparam logic [BIN_W-1:0]  LAST_BIN  = BIN_W'(NUM_BINS - 1);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(ACC_COUNT - 1);

  logic [BIN_W-1:0]  bin_q;
  logic [PASS_W-1:0] pass_q;
  logic              bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      pass_q <= '0;
      bank_q <= 1'b0;
    end else if (adv_i) begin
      if (bin_q == LAST_BIN) begin
        bin_q <= '0;
        if (pass_q == LAST_PASS) begin
          pass_q <= '0;
          bank_q <= ~bank_q;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end else begin
        bin_q <= bin_q + 1'b1;
      end
    end
  end

  assign bin_o   = bin_q;
  assign first_o = (pass_q == '0);
  assign eof_o   = (bin_q == LAST_BIN) && (pass_q == LAST_PASS);
  assign bank_o  = bank_q;

  a_r1_bin_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && (bin_q == LAST_BIN) |=> bin_q == '0);
  a_r1_hold_in_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(bin_q) && $stable(pass_q) && $stable(bank_q));
  a_r7_bank_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && eof_o |=> bank_q != $past(bank_q));
endmodule

// File: rtl/dbi_rmw.sv
module dbi_rmw #(
  parameter int DATA_W = 24,
  parameter int SUM_W  = 36,
  parameter int BIN_W  = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic [BIN_W-1:0]         bin_i,
  input  logic                     bank_i,
  input  logic                     first_i,
  input  logic                     eof_i,
  input  logic [SUM_W-1:0]         rdata_i,
  output logic                     we_o,
  output logic                     wbank_o,
  output logic [BIN_W-1:0]         waddr_o,
  output logic [SUM_W-1:0]         wdata_o,
  output logic                     eof_o
);
  logic                     s1_v, fwd_q;
  logic signed [DATA_W-1:0] s1_smp;
  logic [BIN_W-1:0]         s1_bin;
  logic                     s1_bank, s1_first, s1_eof;
  logic signed [SUM_W-1:0]  fwd_data, base, sum_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v  <= 1'b0;
      fwd_q <= 1'b0;
    end else begin
      s1_v  <= valid_i;
      // RAM read this edge misses the write committing on the same edge
      fwd_q <= valid_i && s1_v && (bin_i == s1_bin) && (bank_i == s1_bank);
    end
  end

  always_ff @(posedge clk_i) begin
    fwd_data <= sum_c;
    if (valid_i) begin
      s1_smp   <= smp_i;
      s1_bin   <= bin_i;
      s1_bank  <= bank_i;
      s1_first <= first_i;
      s1_eof   <= eof_i;
    end
  end

  always_comb begin
    if (s1_first)   base = '0;
    else if (fwd_q) base = fwd_data;
    else            base = $signed(rdata_i);
    sum_c = base + SUM_W'(s1_smp);
  end

  assign we_o    = s1_v;
  assign wbank_o = s1_bank;
  assign waddr_o = s1_bin;
  assign wdata_o = sum_c;
  assign eof_o   = s1_v && s1_eof;

  a_r6_write_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> we_o);
endmodule

// File: rtl/dbi_readout.sv
module dbi_readout #(
  parameter int NUM_BINS = 512,
  parameter int SUM_W    = 36,
  parameter int BIN_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bank_i,
  input  logic [SUM_W-1:0] rdata_i,
  output logic             bank_o,
  output logic [BIN_W-1:0] raddr_o,
  input  logic [BIN_W-1:0] marker_bin_i,
  input  logic [SUM_W-1:0] marker_val_i,
  output logic [SUM_W-1:0] out_sum_o,
  output logic [BIN_W-1:0] out_bin_o,
  output logic             out_last_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             busy_o
);
  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NUM_BINS - 1);

  logic             active_q, pend_q, bank_q, issue;
  logic [BIN_W-1:0] addr_q, paddr_q;

  assign issue = active_q && !pend_q && (!out_valid_o || out_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      pend_q      <= 1'b0;
      bank_q      <= 1'b0;
      addr_q      <= '0;
      paddr_q     <= '0;
      out_valid_o <= 1'b0;
      out_sum_o   <= '0;
      out_bin_o   <= '0;
      out_last_o  <= 1'b0;
    end else begin
      if (start_i) begin
        active_q <= 1'b1;
        addr_q   <= '0;
        bank_q   <= bank_i;
      end else if (issue) begin
        if (addr_q == LAST_BIN) active_q <= 1'b0;
        else                    addr_q   <= addr_q + 1'b1;
      end
      pend_q <= issue;
      if (issue) paddr_q <= addr_q;
      if (pend_q) begin
        out_valid_o <= 1'b1;
        out_sum_o   <= (paddr_q == marker_bin_i) ? marker_val_i : rdata_i;
        out_bin_o   <= paddr_q;
        out_last_o  <= (paddr_q == LAST_BIN);
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  assign bank_o  = bank_q;
  assign raddr_o = addr_q;
  assign busy_o  = active_q || pend_q || out_valid_o;

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_sum_o)
      && $stable(out_bin_o) && $stable(out_last_o));
  a_r4_last_on_final_bin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> out_bin_o == LAST_BIN);
endmodule

// File: rtl/decay_bin_integrator.sv
module decay_bin_integrator import dbi_pkg::*; #(
  parameter int DATA_W    = 24,
  parameter int NUM_BINS  = 512,
  parameter int ACC_COUNT = 4096,
  localparam int BIN_W = idx_w(NUM_BINS),
  localparam int SUM_W = DATA_W + $clog2(ACC_COUNT)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic                     smp_valid_i,
  input  logic [BIN_W-1:0]         marker_bin_i,
  input  logic [SUM_W-1:0]         marker_val_i,
  output logic [SUM_W-1:0]         out_sum_o,
  output logic [BIN_W-1:0]         out_bin_o,
  output logic                     out_last_o,
  output logic                     out_valid_o,
  input  logic                     out_ready_i
);
  logic [BIN_W-1:0] seq_bin, rmw_addr, ro_addr;
  logic             seq_first, seq_eof, seq_bank;
  logic             rmw_we, rmw_bank, rmw_eof, ro_bank, ro_busy;
  logic [SUM_W-1:0] rmw_wdata;
  logic [SUM_W-1:0] rd [2];

  initial a_r2_acc_pow2: assert (ACC_COUNT >= 2 && (ACC_COUNT & (ACC_COUNT - 1)) == 0);

  dbi_bin_seq #(.NUM_BINS(NUM_BINS), .ACC_COUNT(ACC_COUNT)) u_seq (
    .clk_i, .rst_ni, .adv_i(smp_valid_i),
    .bin_o(seq_bin), .first_o(seq_first), .eof_o(seq_eof), .bank_o(seq_bank)
  );

  dbi_rmw #(.DATA_W(DATA_W), .SUM_W(SUM_W), .BIN_W(BIN_W)) u_rmw (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .smp_i,
    .bin_i(seq_bin), .bank_i(seq_bank), .first_i(seq_first), .eof_i(seq_eof),
    .rdata_i(rd[rmw_bank]), .we_o(rmw_we), .wbank_o(rmw_bank),
    .waddr_o(rmw_addr), .wdata_o(rmw_wdata), .eof_o(rmw_eof)
  );

  for (genvar k = 0; k < 2; k++) begin : g_bank
    logic [BIN_W-1:0] raddr;
    // accumulating bank follows the input, the other one the readout
    assign raddr = (seq_bank == 1'(k)) ? seq_bin : ro_addr;
    dbi_bank_ram #(.DEPTH(NUM_BINS), .WIDTH(SUM_W), .AW(BIN_W)) u_ram (
      .clk_i, .we_i(rmw_we && (rmw_bank == 1'(k))), .waddr_i(rmw_addr),
      .wdata_i(rmw_wdata), .raddr_i(raddr), .rdata_o(rd[k])
    );
  end

  dbi_readout #(.NUM_BINS(NUM_BINS), .SUM_W(SUM_W), .BIN_W(BIN_W)) u_ro (
    .clk_i, .rst_ni, .start_i(rmw_eof), .bank_i(rmw_bank), .rdata_i(rd[ro_bank]),
    .bank_o(ro_bank), .raddr_o(ro_addr), .marker_bin_i, .marker_val_i,
    .out_sum_o, .out_bin_o, .out_last_o, .out_valid_o, .out_ready_i, .busy_o(ro_busy)
  );

  a_r7_readout_before_next_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmw_eof |-> !ro_busy);
endmodule

// File: tb/decay_bin_integrator_test.sv
module decay_bin_integrator_test;
  localparam int DW = 24, NB = 8, AC = 4, SW = 26, BW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, smp_valid, o_ready;
  logic signed [DW-1:0] smp;
  logic [BW-1:0] mk_bin, o_bin;
  logic [SW-1:0] mk_val, o_sum, o1_sum;
  logic o_valid, o_last, o1_bin, o1_valid, o1_last;

  decay_bin_integrator #(.DATA_W(DW), .NUM_BINS(NB), .ACC_COUNT(AC)) uut (
    .clk_i(clk), .rst_ni, .smp_i(smp), .smp_valid_i(smp_valid),
    .marker_bin_i(mk_bin), .marker_val_i(mk_val), .out_sum_o(o_sum), .out_bin_o(o_bin),
    .out_last_o(o_last), .out_valid_o(o_valid), .out_ready_i(o_ready));

  // single bin: every sample hits the bin of the previous one (R6)
  decay_bin_integrator #(.DATA_W(DW), .NUM_BINS(1), .ACC_COUNT(AC)) uut_one (
    .clk_i(clk), .rst_ni, .smp_i(smp), .smp_valid_i(smp_valid),
    .marker_bin_i(1'b1), .marker_val_i('0), .out_sum_o(o1_sum), .out_bin_o(o1_bin),
    .out_last_o(o1_last), .out_valid_o(o1_valid), .out_ready_i(1'b1));

  localparam logic signed [DW-1:0] TBL_V [5] = '{24'sd5, -24'sd3, 24'sd8388607, -24'sd8388608, 24'sd0};
  localparam logic signed [SW-1:0] TBL_E [5] = '{26'sd20, -26'sd12, 26'sd33554428, -26'sd33554432, 26'sd0};
  localparam logic [BW-1:0]        TBL_MB[5] = '{3'd0, 3'd3, 3'd7, 3'd2, 3'd5};
  localparam logic [SW-1:0]        TBL_MV[5] = '{26'h0ABCDEF, 26'h1234567, 26'h3FFFFFF, 26'h0000001, 26'h2AAAAAA};

  int n_tests = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
  int mbin = 0, mpass = 0, mpass1 = 0;
  logic signed [SW-1:0] acc [NB];
  logic signed [SW-1:0] acc1, tbl_exp;
  bit tbl_mode = 0;
  string cur_tag = "R3";
  logic [SW-1:0] q_sum[$], q1_sum[$];
  logic [BW-1:0] q_bin[$];
  logic q_last[$];
  string q_tag[$];
  logic hold_chk = 0;
  logic [SW-1:0] hold_sum;
  logic [BW-1:0] hold_bin;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ready for the coming edge is set first, then the transfer is judged
  always @(negedge clk) begin
    cyc++;
    o_ready = (rdy_mode == 0) || (cyc % 3 == 0);
    if (hold_chk)
      check(o_valid === 1'b1 && o_sum == hold_sum && o_bin == hold_bin, "R8",
            "stalled word changed", longint'(o_sum), longint'(hold_sum));
    hold_chk = o_valid && !o_ready;
    hold_sum = o_sum;
    hold_bin = o_bin;
    if (o_valid === 1'b1 && o_ready) begin
      if (q_sum.size() == 0) check(0, "R4", "unexpected word", longint'(o_bin), -1);
      else begin
        automatic logic [SW-1:0] es = q_sum.pop_front();
        automatic logic [BW-1:0] eb = q_bin.pop_front();
        automatic logic el = q_last.pop_front();
        automatic string tg = q_tag.pop_front();
        check(o_bin == eb && o_last == el, "R4", "bin/last", longint'({o_bin, o_last}), longint'({eb, el}));
        check(o_sum == es, tg, "sum", longint'($signed(o_sum)), longint'($signed(es)));
      end
    end
    if (o1_valid === 1'b1) begin
      if (q1_sum.size() == 0) check(0, "R6", "unexpected single-bin word", longint'($signed(o1_sum)), -1);
      else begin
        automatic logic [SW-1:0] es1 = q1_sum.pop_front();
        check(o1_sum == es1 && o1_last == 1'b1 && o1_bin == 1'b0, "R6", "single-bin sum",
              longint'($signed(o1_sum)), longint'($signed(es1)));
      end
    end
  end

  function automatic logic signed [DW-1:0] ramp(input int k);
    return DW'(((k * 7919) % 65536) - 32768);
  endfunction

  task automatic put(input logic signed [DW-1:0] v, input int gap);
    @(negedge clk);
    smp = v;
    smp_valid = 1'b1;
    if (mpass == 0) acc[mbin] = SW'(v);
    else            acc[mbin] = acc[mbin] + SW'(v);
    if (mbin == NB - 1) begin
      mbin = 0;
      if (mpass == AC - 1) begin
        mpass = 0;
        for (int b = 0; b < NB; b++) begin
          q_sum.push_back((b == int'(mk_bin)) ? mk_val : (tbl_mode ? tbl_exp : acc[b]));
          q_bin.push_back(BW'(b));
          q_last.push_back(b == NB - 1);
          q_tag.push_back((b == int'(mk_bin)) ? "R5" : cur_tag);
        end
      end else mpass++;
    end else mbin++;
    if (mpass1 == 0) acc1 = SW'(v);
    else             acc1 = acc1 + SW'(v);
    if (mpass1 == AC - 1) begin
      mpass1 = 0;
      q1_sum.push_back(acc1);
    end else mpass1++;
    repeat (gap) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (80) @(negedge clk);
    check(q_sum.size() == 0 && q1_sum.size() == 0, tag, "words missing after frame",
          longint'(q_sum.size() + q1_sum.size()), 0);
  endtask

  initial begin
    rst_ni = 1'b0; smp = '0; smp_valid = 1'b0; mk_bin = 3'd7; mk_val = '0;
    repeat (3) @(negedge clk);
    check(o_valid === 1'b0 && o1_valid === 1'b0, "R9", "out_valid in reset", longint'(o_valid), 0);
    rst_ni = 1'b1;

    // table: constant frames, each expected sum = AC * value (R2 full scale, R3 reload, R5 marker)
    tbl_mode = 1;
    for (int i = 0; i < 5; i++) begin
      mk_bin = TBL_MB[i];
      mk_val = TBL_MV[i];
      tbl_exp = TBL_E[i];
      cur_tag = (i == 2 || i == 3) ? "R2" : "R3";
      for (int k = 0; k < NB * AC; k++) put(TBL_V[i], 0);
      drain("R4");
    end
    tbl_mode = 0;
    mk_bin = 3'd6;
    mk_val = 26'h0055AA5;

    // R7: three frames back to back through the bank swap
    cur_tag = "R7";
    for (int k = 0; k < 3 * NB * AC; k++) put(ramp(k), 0);
    drain("R7");

    // R1: irregular strobe gaps do not move bins
    cur_tag = "R1";
    for (int k = 0; k < NB * AC; k++) put(ramp(k + 500), k % 3);
    drain("R1");

    // R8: backpressure during readout
    rdy_mode = 1;
    cur_tag = "R8";
    for (int k = 0; k < 2 * NB * AC; k++) put(ramp(3 * k + 11), 1);
    drain("R8");
    rdy_mode = 0;

    // R9: reset in mid-frame, next frame starts fresh at bin 0
    for (int k = 0; k < 13; k++) put(24'sd100000, 0);
    @(negedge clk); smp_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    mbin = 0; mpass = 0; mpass1 = 0;
    repeat (2) @(negedge clk);
    check(o_valid === 1'b0 && o1_valid === 1'b0, "R9", "out_valid after mid-frame reset", longint'(o_valid), 0);
    rst_ni = 1'b1;
    cur_tag = "R9";
    for (int k = 0; k < NB * AC; k++) put(ramp(7 * k), 0);
    drain("R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule